// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block sits between a simple on-chip read port and a serial flash device. A bus read names a chip select, a byte offset into the mapped window and a length. The block turns it into one complete flash read sequence: it lowers the chip select, sends the read opcode, the address bytes and any dummy bytes on a single line, and then clocks in the data on one, two or four lines. When every requested byte has arrived, it returns them on the read port and releases the chip select.

Each chip select has its own setup word. That word holds the opcode, the address byte count, the dummy byte count and the data line width, so parts with different read commands can share the bus. A mode bit enables the window. While the bit is clear, reads are refused and the serial bus stays quiet, which leaves the bus free for the command-driven path. Reads that would run past the end of the window are refused in the same way. The serial clock idles low, and data is launched on its falling edge and sampled on its rising edge.

Top module: `flash_window_reader`

## Requirements
- R1: Bit 0 of the mode register (byte offset 0x64 on the config port) enables the window; it resets to 0. While it is 0, an accepted read returns `rd_err`=1. No chip select is lowered and `sclk` does not toggle.
- R2: The setup word for chip select n is written at byte offset 0x54 + 4n. A read uses the setup word of the chip select given in `rd_cs` and lowers only `cs_n[rd_cs]`.
- R3: Setup word bits [7:0] are the opcode sent first. Bits [9:8] hold the address byte count minus one, so 1 to 4 address bytes follow the opcode.
- R4: Setup bits [11:10] give 0 to 3 dummy bytes. These are clocked after the address, with `io_out[0]`=0 and only `io_oe[0]` set.
- R5: Setup bits [13:12] pick the data width: 0 one line (`io_in[0]`), 1 two lines (`io_in[1:0]`, `io_in[1]` the earlier bit), 3 four lines (`io_in[3:0]`, `io_in[3]` the earliest bit). Code 2 acts as one line. Each byte arrives most significant bit first, and the data phase lasts len*8/width clocks.
- R6: A read is refused with `rd_err`=1 and no bus activity in any of these cases: `rd_addr`+`rd_len` exceeds WIN_BYTES, `rd_len` is 0, `rd_len` exceeds MAXLEN, or `rd_cs` is not below NCS. A read ending exactly at WIN_BYTES is served.
- R7: The opcode, address and dummy phases go out on `io_out[0]` only, most significant bit first. The address sent is the low address-byte-count bytes of `rd_addr`.
- R8: `rd_ready` is high only when idle. A request with `rd_ready` low is ignored. After acceptance, `rd_ready` stays low until `rd_valid`, which is a one-cycle pulse followed by `rd_ready` high.
- R9: At most one chip select is low at a time. All are high, and `sclk` is low, whenever `rd_valid` is high or no sequence runs.
- R10: `rd_data[8i+7:8i]` is the byte read from offset `rd_addr`+i. Bytes at or above `rd_len`, and all bytes of a refused read, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 8 | Config register byte offset |
| cfg_wdata | input | 32 | Config write data |
| rd_req | input | 1 | Read request, taken when rd_ready is high |
| rd_cs | input | $clog2(NCS) | Chip select for the read |
| rd_addr | input | 32 | Byte offset into the window |
| rd_len | input | $clog2(MAXLEN+1) | Bytes to read |
| rd_ready | output | 1 | Idle and able to accept a read |
| rd_valid | output | 1 | One-cycle completion pulse |
| rd_err | output | 1 | Read refused (valid with rd_valid) |
| rd_data | output | 8*MAXLEN | Read bytes, first byte lowest |
| sclk | output | 1 | Serial clock |
| cs_n | output | NCS | Active-low chip selects |
| io_out | output | 4 | Serial data out |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Serial data in |

## Verification
The assertions check on every cycle the properties that do not depend on data content. These are: at most one chip select is low, the serial clock stays quiet while no select is low, and the upper three lines are never driven. They also check the ready/valid handshake and the release of the bus at completion, and that a read taken while the mode bit is clear is refused at once. Only the bench scenarios can show the field decoding of the setup words and the per-select choice of word. The same holds for address truncation, the dummy bytes, the bit order on one, two and four lines, and the byte placement in `rd_data`. They need a flash model that captures the header bits and supplies known data. The window bounds and the dropping of requests during a transfer are also shown only by the scenarios.

// File: rtl/flash_window_reader.sv
module flash_window_reader #(
  parameter int NCS       = 4,
  parameter int MAXLEN    = 8,
  parameter int WIN_BYTES = 65536
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [7:0]                    cfg_addr,
  input  logic [31:0]                   cfg_wdata,
  input  logic                          rd_req,
  input  logic [$clog2(NCS)-1:0]        rd_cs,
  input  logic [31:0]                   rd_addr,
  input  logic [$clog2(MAXLEN+1)-1:0]   rd_len,
  output logic                          rd_ready,
  output logic                          rd_valid,
  output logic                          rd_err,
  output logic [8*MAXLEN-1:0]           rd_data,
  output logic                          sclk,
  output logic [NCS-1:0]                cs_n,
  output logic [3:0]                    io_out,
  output logic [3:0]                    io_oe,
  input  logic [3:0]                    io_in
);
  localparam int CSW = $clog2(NCS);
  localparam int LW  = $clog2(MAXLEN+1);
  localparam int BW  = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
  localparam int CW  = $clog2(MAXLEN*8 + 41);
  localparam logic [7:0] MODE_OFS  = 8'h64;
  localparam logic [7:0] SETUP_OFS = 8'h54;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DUM, S_DAT, S_DONE} st_t;

  st_t              st;
  logic             sw_en, ph, err_q;
  logic [13:0]      setup [NCS];
  logic [CW-1:0]    cnt, beats_q;
  logic [39:0]      tx;
  logic [CSW-1:0]   cs_q;
  logic [1:0]       wsh, dum;
  logic [7:0]       bsh, nbyte;
  logic [2:0]       bcnt;
  logic [3:0]       nbc;
  logic [BW-1:0]    bidx;
  logic [8*MAXLEN-1:0] rx;
  logic [13:0]      sel;
  logic [1:0]       wcode;
  logic [31:0]      ashift;
  logic             req_ok, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en <= 1'b0;
      for (int i = 0; i < NCS; i++) setup[i] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == MODE_OFS) sw_en <= cfg_wdata[0];
      for (int i = 0; i < NCS; i++)
        if (cfg_addr == SETUP_OFS + 8'(4*i)) setup[i] <= cfg_wdata[13:0];
    end
  end

  assign sel    = (32'(rd_cs) < NCS) ? setup[rd_cs] : '0;
  assign wcode  = (sel[13:12] == 2'd1) ? 2'd1 : (sel[13:12] == 2'd3) ? 2'd2 : 2'd0;
  assign ashift = rd_addr << (5'd8 * (5'd3 - {3'b0, sel[9:8]}));
  assign req_ok = sw_en && (rd_len != '0) && (32'(rd_len) <= MAXLEN) &&
                  (32'(rd_cs) < NCS) &&
                  ({1'b0, rd_addr} + 33'(rd_len) <= 33'(WIN_BYTES));

  always_comb begin
    case (wsh)
      2'd1:    nbyte = {bsh[5:0], io_in[1:0]};
      2'd2:    nbyte = {bsh[3:0], io_in[3:0]};
      default: nbyte = {bsh[6:0], io_in[0]};
    endcase
    nbc = {1'b0, bcnt} + (4'd1 << wsh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; err_q <= 1'b0; cnt <= '0; beats_q <= '0;
      tx <= '0; cs_q <= '0; wsh <= '0; dum <= '0; bsh <= '0; bcnt <= '0;
      bidx <= '0; rx <= '0;
    end else begin
      case (st)
        S_IDLE: if (rd_req) begin
          err_q <= !req_ok;
          rx    <= '0;
          bcnt  <= '0;
          bidx  <= '0;
          bsh   <= '0;
          ph    <= 1'b0;
          if (req_ok) begin
            st      <= S_HDR;
            cs_q    <= rd_cs;
            tx      <= {sel[7:0], ashift};
            cnt     <= CW'(16) + CW'({sel[9:8], 3'b000});
            dum     <= sel[11:10];
            wsh     <= wcode;
            beats_q <= CW'({rd_len, 3'b000} >> wcode);
          end else begin
            st <= S_DONE;
          end
        end
        S_HDR, S_DUM, S_DAT: begin
          ph <= ~ph;
          if (ph) begin
            if (st == S_HDR) tx <= {tx[38:0], 1'b0};
            if (st == S_DAT) begin
              bsh <= nbyte;
              if (nbc[3]) begin
                rx[{bidx, 3'b000} +: 8] <= nbyte;
                bidx <= bidx + 1'b1;
                bcnt <= '0;
              end else begin
                bcnt <= nbc[2:0];
              end
            end
            if (cnt == CW'(1)) begin
              if (st == S_HDR && dum != 2'd0) begin
                st  <= S_DUM;
                cnt <= CW'({dum, 3'b000});
              end else if (st == S_DAT) begin
                st <= S_DONE;
              end else begin
                st  <= S_DAT;
                cnt <= beats_q;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign active   = (st == S_HDR) || (st == S_DUM) || (st == S_DAT);
  assign rd_ready = (st == S_IDLE);
  assign rd_valid = (st == S_DONE);
  assign rd_err   = err_q;
  assign rd_data  = rx;
  assign sclk     = ph;
  assign io_out   = {3'b000, (st == S_HDR) ? tx[39] : 1'b0};
  assign io_oe    = {3'b000, (st == S_HDR) || (st == S_DUM)};

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = !(active && cs_q == CSW'(i));
  end
endmodule

module flash_window_reader_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_req,
  input logic           rd_ready,
  input logic           rd_valid,
  input logic           rd_err,
  input logic           sw_en,
  input logic           sclk,
  input logic [NCS-1:0] cs_n,
  input logic [3:0]     io_oe
);
  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r9_quiet_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sclk);
  a_r9_release_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((&cs_n) && !sclk));
  a_r1_off_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ready && !sw_en) |=> (rd_valid && rd_err));
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ready) |=> !rd_ready);
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> (!rd_valid && rd_ready));
  a_r8_not_ready_at_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rd_ready);
  a_r7_single_line_out: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe[3:1] == 3'b000);
endmodule

bind flash_window_reader flash_window_reader_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ready(rd_ready),
  .rd_valid(rd_valid), .rd_err(rd_err), .sw_en(sw_en), .sclk(sclk),
  .cs_n(cs_n), .io_oe(io_oe)
);

// File: tb/sim_flash_window_reader.sv
`timescale 1ns/1ps
module sim_flash_window_reader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic rd_req = 1'b0;
  logic [1:0] rd_cs = '0;
  logic [31:0] rd_addr = '0;
  logic [3:0] rd_len = '0;
  logic rd_ready, rd_valid, rd_err, sclk;
  logic [63:0] rd_data;
  logic [3:0] cs_n, io_out, io_oe;
  logic [3:0] io_in = '0;

  always #2.5 clk = ~clk;

  flash_window_reader u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_req(rd_req), .rd_cs(rd_cs), .rd_addr(rd_addr),
    .rd_len(rd_len), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_err(rd_err),
    .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
    .io_oe(io_oe), .io_in(io_in));

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // flash model state
  int m_nb = 3, m_dm = 0, m_w = 1;
  int rises = 0, n_sel = 0, n_valid = 0;
  logic [7:0] cap_op = '0;
  logic [31:0] cap_ad = '0;
  logic [3:0] seen = '0;
  bit bad = 1'b0;
  wire cs_any = ~&cs_n;

  function automatic logic [7:0] fmem(input logic [31:0] a);
    return a[7:0] * 8'd29 + a[15:8] + 8'h11;
  endfunction

  function automatic int hdr_bits();
    return 8 + 8*m_nb + 8*m_dm;
  endfunction

  always @(posedge cs_any) begin
    rises = 0; cap_op = '0; cap_ad = '0; io_in = '0; n_sel++;
  end

  always @(posedge sclk) begin
    if (rises < 8) cap_op = {cap_op[6:0], io_out[0]};
    else if (rises < 8 + 8*m_nb) cap_ad = {cap_ad[30:0], io_out[0]};
    else if (rises < hdr_bits()) begin
      if (io_oe != 4'b0001 || io_out[0] != 1'b0) bad = 1'b1;
    end else if (io_oe != 4'b0000) bad = 1'b1;
    if (rises < 8 + 8*m_nb && io_oe != 4'b0001) bad = 1'b1;
    rises++;
  end

  always @(negedge sclk) begin
    if (cs_any && rises >= hdr_bits()) begin
      int bo;
      logic [7:0] t;
      bo = (rises - hdr_bits()) * m_w;
      t  = fmem(cap_ad + 32'(bo / 8)) << (bo % 8);
      if (m_w == 1) io_in = {3'b000, t[7]};
      else if (m_w == 2) io_in = {2'b00, t[7:6]};
      else io_in = t[7:4];
    end
  end

  always @(posedge clk) begin
    if (cs_any) seen <= seen | ~cs_n;
    if (rd_valid) n_valid <= n_valid + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] sw(input logic [7:0] op, input int nb,
                                     input int dm, input int wc);
    return {18'b0, 2'(wc), 2'(dm), 2'(nb - 1), op};
  endfunction

  task automatic do_read(input int cs, input logic [31:0] a, input int len,
                         input int nb, input int dm, input int w,
                         output logic [63:0] d, output logic e);
    m_nb = nb; m_dm = dm; m_w = w;
    @(negedge clk);
    seen = '0; bad = 1'b0; rises = 0;
    rd_cs = 2'(cs); rd_addr = a; rd_len = 4'(len); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    while (!rd_valid) @(negedge clk);
    d = rd_data; e = rd_err;
    @(negedge clk);
  endtask

  task automatic good_read(input string req, input int cs, input logic [31:0] a,
                           input int len, input logic [7:0] op, input int nb,
                           input int dm, input int w);
    logic [63:0] d, exp;
    logic e;
    logic [31:0] ta;
    ta = (nb == 4) ? a : (a & ((32'd1 << (8*nb)) - 1));
    exp = '0;
    for (int i = 0; i < len; i++) exp[8*i +: 8] = fmem(ta + 32'(i));
    do_read(cs, a, len, nb, dm, w, d, e);
    check(e == 1'b0, req, "no error", 64'(e), 64'd0);
    check(d == exp, "R10", "read data", d, exp);
    check(cap_op == op, "R3", "opcode", 64'(cap_op), 64'(op));
    check(cap_ad == ta, "R7", "truncated address", 64'(cap_ad), 64'(ta));
    check(rises == hdr_bits() + len*8/w, req, "clock count",
          64'(rises), 64'(hdr_bits() + len*8/w));
    check(seen == 4'(1 << cs), "R2", "selected line", 64'(seen), 64'(1 << cs));
    check(!bad, "R4", "header/dummy line use", 64'(bad), 64'd0);
    check(&cs_n && !sclk, "R9", "bus released", {cs_n, 3'b0, sclk}, 64'hf0);
  endtask

  task automatic bad_read(input string req, input int cs, input logic [31:0] a,
                          input int len);
    logic [63:0] d;
    logic e;
    int s0;
    s0 = n_sel;
    do_read(cs, a, len, 3, 0, 1, d, e);
    check(e == 1'b1, req, "refused", 64'(e), 64'd1);
    check(d == 64'd0, "R10", "refused data zero", d, 64'd0);
    check(n_sel == s0 && rises == 0, req, "no bus activity",
          64'(n_sel - s0 + rises), 64'd0);
  endtask

  task automatic t_reset();
    check(rd_ready == 1'b1, "R8", "ready after reset", 64'(rd_ready), 64'd1);
    check(rd_valid == 1'b0, "R8", "valid after reset", 64'(rd_valid), 64'd0);
    check(cs_n == 4'hf && sclk == 1'b0, "R9", "idle bus", {cs_n, 3'b0, sclk}, 64'hf0);
    check(io_oe == 4'h0, "R7", "no drive at reset", 64'(io_oe), 64'd0);
  endtask

  task automatic t_mode_off();
    bad_read("R1", 0, 32'h10, 4);
    wr_cfg(8'h64, 32'h1);
  endtask

  task automatic t_single();
    wr_cfg(8'h54, sw(8'h03, 3, 0, 0));
    good_read("R3", 0, 32'h1234, 4, 8'h03, 3, 0, 1);
    good_read("R7", 0, 32'h00FF, 1, 8'h03, 3, 0, 1);
  endtask

  task automatic t_widths();
    wr_cfg(8'h54, sw(8'h3B, 3, 1, 1));
    good_read("R5", 0, 32'h0420, 5, 8'h3B, 3, 1, 2);
    wr_cfg(8'h54, sw(8'h6B, 4, 3, 3));
    good_read("R5", 0, 32'hC0DE, 8, 8'h6B, 4, 3, 4);
    wr_cfg(8'h54, sw(8'h0C, 2, 2, 2));
    good_read("R5", 0, 32'h7001, 3, 8'h0C, 2, 2, 1);
  endtask

  task automatic t_addr();
    wr_cfg(8'h54, sw(8'h13, 1, 0, 0));
    good_read("R7", 0, 32'hABCD, 2, 8'h13, 1, 0, 1);
    wr_cfg(8'h54, sw(8'hEB, 2, 0, 3));
    good_read("R7", 0, 32'h5A3C, 6, 8'hEB, 2, 0, 4);
  endtask

  task automatic t_per_cs();
    wr_cfg(8'h5C, sw(8'hA5, 2, 0, 0));
    wr_cfg(8'h58, sw(8'h0B, 3, 1, 1));
    good_read("R2", 2, 32'h0102, 3, 8'hA5, 2, 0, 1);
    good_read("R2", 1, 32'h0304, 4, 8'h0B, 3, 1, 2);
  endtask

  task automatic t_window();
    wr_cfg(8'h54, sw(8'h03, 3, 0, 0));
    good_read("R6", 0, 32'hFFF8, 8, 8'h03, 3, 0, 1);
    bad_read("R6", 0, 32'hFFF9, 8);
    bad_read("R6", 0, 32'h0000, 0);
    bad_read("R6", 0, 32'h0000, 9);
    bad_read("R6", 0, 32'h12345, 1);
  endtask

  task automatic t_busy();
    logic [63:0] exp;
    int s0, v0;
    wr_cfg(8'h54, sw(8'h03, 3, 0, 0));
    m_nb = 3; m_dm = 0; m_w = 1;
    s0 = n_sel; v0 = n_valid;
    exp = '0;
    for (int i = 0; i < 2; i++) exp[8*i +: 8] = fmem(32'h0200 + 32'(i));
    @(negedge clk);
    rd_cs = 2'd0; rd_addr = 32'h0200; rd_len = 4'd2; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    repeat (10) @(negedge clk);
    check(rd_ready == 1'b0, "R8", "busy not ready", 64'(rd_ready), 64'd0);
    rd_addr = 32'h0300; rd_cs = 2'd1; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    while (!rd_valid) @(negedge clk);
    check(rd_data == exp, "R8", "first read data kept", rd_data, exp);
    repeat (120) @(negedge clk);
    check(n_sel - s0 == 1, "R8", "one sequence", 64'(n_sel - s0), 64'd1);
    check(n_valid - v0 == 1, "R8", "one completion", 64'(n_valid - v0), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_off();
    t_single();
    t_widths();
    t_addr();
    t_per_cs();
    t_window();
    t_busy();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule